// File: doc/BRIEF.md
# Configurable External Interrupt Detector

This block watches a small set of asynchronous interrupt pins and turns each into a request for the interrupt controller. Every channel has its own control byte. The byte chooses edge or level sensing, the active polarity and a 3-bit priority level. A pin first passes a two-flop synchronizer. It then passes a width filter, which accepts a new level only after the level has held for the number of clock cycles that makes up the minimum pulse width (250 ns by default). The cycle count is derived from the clock frequency parameter.

In edge mode a qualified edge sets a sticky flag, and the channel's acknowledge pulse clears it. In level mode the request follows the filtered pin level, and acknowledge does nothing. A priority level of zero hides a channel's request, which is how an unused channel is switched off. The synchronized pin levels can be read at any time through a status address, even while the pins serve as interrupt inputs. Arbitration between channels is left to the interrupt controller, which receives the requests and the priority levels.

Top module: `ext_irq_detector`

## Requirements
- R1: The control byte of channel i is written and read at address i. Bit 5 selects the sense mode (0 = edge, 1 = level). Bit 4 selects polarity (0 = falling edge or low level, 1 = rising edge or high level). Bits 2:0 hold the priority. Bits 7:6 and 3 read as 0. All control bytes reset to 0.
- R2: In edge mode, a qualified edge in the selected direction sets a sticky request. If the pin changes before rising clock edge k, the request shows after edge k+N+2, where N is the filter length (25 cycles at 100 MHz). The request stays set after the pin returns.
- R3: A pin level held for fewer than N cycles produces no request in any mode. A level held for N cycles is accepted.
- R4: In level mode, the request is high exactly while the filtered level equals the polarity bit. It shows after edge k+N+1 and drops one filter length after the pin leaves the active level.
- R5: In level mode, the acknowledge input has no effect on the request.
- R6: A channel whose priority is 0 never raises its request. A pending edge flag survives, and it shows again once a non-zero priority is written.
- R7: An acknowledge pulse clears a pending edge request. If the acknowledge and a new qualified edge fall in the same cycle, the request stays set.
- R8: A write that changes the sense or polarity bit clears a pending edge request. A write that leaves both bits unchanged keeps it.
- R9: Address NUM_CH (3) reads the synchronized pin levels in bits NUM_CH-1:0, two cycles behind the pins, in every mode. `pin_state_o` carries the same levels.
- R10: After reset all requests are low and the filters hold the idle level (high), so reset release raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_CH | Asynchronous interrupt pins |
| ack_i | input | NUM_CH | Per-channel acknowledge pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address (channel control or pin status) |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Combinational read data for addr_i |
| req_o | output | NUM_CH | Interrupt requests after priority masking |
| pin_state_o | output | NUM_CH | Synchronized pin levels |
| prio_o | output | NUM_CH*3 | Priority level of each channel |

## Verification
The assertions check on every cycle the rules that follow from one cycle's state. The filter changes only when its counter is at the limit, and the counter never passes that limit. A zero priority masks the request. An acknowledge clears the flag unless an edge arrives in the same cycle, and a mode change always clears it. Only the bench's scenarios can show the end-to-end timing: the exact latency from pin to request, the rejection of a pulse one cycle too short, the level request falling after the pin releases, a flag surviving while masked, and the status read of all eight pin patterns.

// File: rtl/irq_det_pkg.sv
`timescale 1ns/1ps
package irq_det_pkg;
  localparam int unsigned PRIO_W     = 3;
  localparam int unsigned CTRL_W     = 8;
  localparam int unsigned SENSE_BIT  = 5;
  localparam int unsigned POL_BIT    = 4;

  typedef struct packed {
    logic              sense;  // 1 = level
    logic              pol;    // 1 = rising/high
    logic [PRIO_W-1:0] prio;
  } irq_cfg_t;

  function automatic logic [CTRL_W-1:0] cfg_pack(input irq_cfg_t c);
    logic [CTRL_W-1:0] b;
    b            = '0;
    b[SENSE_BIT] = c.sense;
    b[POL_BIT]   = c.pol;
    b[PRIO_W-1:0] = c.prio;
    return b;
  endfunction

  function automatic irq_cfg_t cfg_unpack(input logic [CTRL_W-1:0] b);
    irq_cfg_t c;
    c.sense = b[SENSE_BIT];
    c.pol   = b[POL_BIT];
    c.prio  = b[PRIO_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
  parameter bit IDLE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= IDLE;
      sync_q <= IDLE;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/irq_width_filter.sv
`timescale 1ns/1ps
module irq_width_filter #(
  parameter int unsigned CYCLES = 25,
  parameter bit          IDLE   = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic          q_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= IDLE;
      cnt_q <= '0;
    end else if (d_i == q_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      q_q   <= d_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = q_q;

  // R3
  filt_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(q_q) |-> ($past(cnt_q) == LAST && $past(d_i) != $past(q_q)));

  // R3
  filt_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/irq_channel.sv
`timescale 1ns/1ps
module irq_channel
  import irq_det_pkg::*;
#(
  parameter int unsigned FILT_CYCLES = 25,
  parameter bit          IDLE        = 1'b1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pin_i,
  input  logic     ack_i,
  input  logic     cfg_we_i,
  input  irq_cfg_t cfg_wdata_i,
  output irq_cfg_t cfg_o,
  output logic     pin_sync_o,
  output logic     req_o
);
  irq_cfg_t cfg_q;
  logic     pin_sync, filt, filt_d1_q, flag_q;
  logic     mode_chg, rise, fall, edge_hit, level_act, raw_req;

  irq_sync #(.IDLE(IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  irq_width_filter #(.CYCLES(FILT_CYCLES), .IDLE(IDLE)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_sync),
    .q_o   (filt)
  );

  assign mode_chg  = cfg_we_i && ((cfg_wdata_i.sense != cfg_q.sense) ||
                                  (cfg_wdata_i.pol   != cfg_q.pol));
  assign rise      = filt & ~filt_d1_q;
  assign fall      = ~filt & filt_d1_q;
  assign edge_hit  = !cfg_q.sense && (cfg_q.pol ? rise : fall);
  assign level_act = cfg_q.sense && (filt == cfg_q.pol);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      filt_d1_q <= IDLE;
      flag_q    <= 1'b0;
    end else begin
      if (cfg_we_i) cfg_q <= cfg_wdata_i;
      filt_d1_q <= filt;
      if (mode_chg)      flag_q <= 1'b0;
      else if (edge_hit) flag_q <= 1'b1;   // new edge beats ack
      else if (ack_i)    flag_q <= 1'b0;
    end
  end

  assign raw_req    = cfg_q.sense ? level_act : flag_q;
  assign req_o      = (cfg_q.prio != '0) && raw_req;
  assign cfg_o      = cfg_q;
  assign pin_sync_o = pin_sync;

  // R6
  prio_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.prio == '0) |-> !req_o);

  // R8
  mode_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> !flag_q);

  // R7
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !edge_hit && !cfg_we_i) |=> !flag_q);

  // R7
  edge_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_hit && !mode_chg) |=> flag_q);

  // R5
  level_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.sense && level_act && ack_i && !cfg_we_i && $stable(filt)) |=>
      (raw_req || !$stable(filt)));
endmodule

// File: rtl/ext_irq_detector.sv
`timescale 1ns/1ps
module ext_irq_detector
  import irq_det_pkg::*;
#(
  parameter int unsigned NUM_CH       = 3,
  parameter int unsigned CLK_FREQ_HZ  = 100_000_000,
  parameter int unsigned MIN_WIDTH_NS = 250,
  parameter bit          IDLE_LEVEL   = 1'b1,
  parameter int unsigned ADDR_W       = $clog2(NUM_CH + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH-1:0]        pin_i,
  input  logic [NUM_CH-1:0]        ack_i,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [CTRL_W-1:0]        wr_data_i,
  output logic [CTRL_W-1:0]        rd_data_o,
  output logic [NUM_CH-1:0]        req_o,
  output logic [NUM_CH-1:0]        pin_state_o,
  output logic [NUM_CH*PRIO_W-1:0] prio_o
);
  localparam int unsigned KHZ         = CLK_FREQ_HZ / 1000;
  localparam int unsigned FILT_RAW    = (KHZ * MIN_WIDTH_NS + 999_999) / 1_000_000;
  localparam int unsigned FILT_CYCLES = (FILT_RAW < 1) ? 1 : FILT_RAW;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_CH);

  irq_cfg_t cfg_arr [NUM_CH];
  irq_cfg_t wcfg;
  logic     unused_wbits;

  assign wcfg         = cfg_unpack(wr_data_i);
  assign unused_wbits = ^{wr_data_i[7:6], wr_data_i[3]};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic we;
    assign we = wr_en_i && (addr_i == ADDR_W'(g));

    irq_channel #(.FILT_CYCLES(FILT_CYCLES), .IDLE(IDLE_LEVEL)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (pin_i[g]),
      .ack_i      (ack_i[g]),
      .cfg_we_i   (we),
      .cfg_wdata_i(wcfg),
      .cfg_o      (cfg_arr[g]),
      .pin_sync_o (pin_state_o[g]),
      .req_o      (req_o[g])
    );

    assign prio_o[g*PRIO_W +: PRIO_W] = cfg_arr[g].prio;
  end

  always_comb begin
    rd_data_o = '0;
    if (addr_i == STAT_ADDR) begin
      rd_data_o[NUM_CH-1:0] = pin_state_o;
    end else begin
      for (int i = 0; i < NUM_CH; i++)
        if (addr_i == ADDR_W'(i)) rd_data_o = cfg_pack(cfg_arr[i]);
    end
  end

  // R9
  stat_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == STAT_ADDR) |-> (rd_data_o[NUM_CH-1:0] == pin_state_o));
endmodule

// File: tb/ext_irq_detector_tb.sv
`timescale 1ns/1ps
module ext_irq_detector_tb;
  localparam int NCH = 3;
  localparam int N   = (250 * 100 + 999) / 1000;  // 250 ns at 100 MHz

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pin = 3'b111;
  logic [2:0] ack = '0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] req, pst;
  logic [8:0] prio;
  int vec = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ext_irq_detector u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .ack_i(ack),
    .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wdata),
    .rd_data_o(rdata), .req_o(req), .pin_state_o(pst), .prio_o(prio)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    wr_en = 1'b1; addr = 2'(a); wdata = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    addr = 2'(a);
    #1 d = rdata;
  endtask

  task automatic ack_pulse(input int c);
    ack[c] = 1'b1; cyc(1); ack[c] = 1'b0;
  endtask

  function automatic logic [7:0] ctl(input bit s, input bit p, input logic [2:0] pr);
    return {2'b00, s, p, 1'b0, pr};
  endfunction

  // one channel, one mode: settle, glitch, exact latency, release
  task automatic run_mode(input int c, input bit s, input bit p);
    logic [7:0] d;
    logic       seen;
    wr(c, ctl(s, p, 3'd5));
    rd(c, d);
    chk(d, ctl(s, p, 3'd5), "R1 readback");
    pin[c] = ~p; cyc(N + 6); ack_pulse(c); cyc(1);
    chk({7'd0, req[c]}, 8'd0, "R2/R4 idle");
    // R3: N-1 cycle pulse rejected
    seen = 1'b0;
    pin[c] = p;
    for (int i = 0; i < N - 1; i++) begin cyc(1); seen |= req[c]; end
    pin[c] = ~p;
    for (int i = 0; i < N + 6; i++) begin cyc(1); seen |= req[c]; end
    chk({7'd0, seen}, 8'd0, "R3 short pulse");
    // exact latency: level N+2 negedges, edge N+3
    pin[c] = p;
    cyc(s ? N + 1 : N + 2);
    chk({7'd0, req[c]}, 8'd0, s ? "R4 early" : "R2 early");
    cyc(1);
    chk({7'd0, req[c]}, 8'd1, s ? "R4 latency" : "R2 latency");
    if (s) begin
      ack_pulse(c); cyc(1);
      chk({7'd0, req[c]}, 8'd1, "R5 ack ignored");
    end
    cyc(4);
    pin[c] = ~p; cyc(N + 4);
    chk({7'd0, req[c]}, s ? 8'd0 : 8'd1, s ? "R4 release" : "R2 sticky");
    if (!s) begin
      ack_pulse(c);
      chk({7'd0, req[c]}, 8'd0, "R7 ack clears");
    end
  endtask

  initial begin
    logic [7:0] d;
    cyc(3); rst_n = 1'b1; cyc(2);
    // R10 reset state
    chk({5'd0, req}, 8'd0, "R10 req");
    for (int c = 0; c < NCH; c++) begin
      rd(c, d); chk(d, 8'd0, "R10/R1 ctrl");
    end
    // R9 all pin patterns, two-cycle latency
    for (int v = 0; v < 8; v++) begin
      logic [2:0] prev;
      prev = pin;
      pin = 3'(v);
      cyc(1); rd(3, d); chk(d, {5'd0, prev}, "R9 status hold");
      cyc(1); rd(3, d); chk(d, 8'(v), "R9 status");
      chk({5'd0, pst}, 8'(v), "R9 pin_state_o");
    end
    pin = 3'b111; cyc(N + 6);
    // R1 reserved bits read zero
    wr(0, 8'hFF); rd(0, d); chk(d, 8'h37, "R1 reserved");
    wr(0, 8'h00); rd(0, d); chk(d, 8'h00, "R1 clear");
    // all channels, all four modes
    for (int c = 0; c < NCH; c++)
      for (int m = 0; m < 4; m++)
        run_mode(c, m[1], m[0]);
    // R7 collision on ch0 falling
    wr(0, ctl(0, 0, 3'd2));
    pin[0] = 1'b1; cyc(N + 6); ack_pulse(0);
    pin[0] = 1'b0; cyc(N + 6);
    pin[0] = 1'b1; cyc(N + 6);
    chk({7'd0, req[0]}, 8'd1, "R7 pending");
    pin[0] = 1'b0; cyc(N + 2);
    ack[0] = 1'b1; cyc(1); ack[0] = 1'b0;
    chk({7'd0, req[0]}, 8'd1, "R7 edge wins");
    ack_pulse(0);
    chk({7'd0, req[0]}, 8'd0, "R7 ack after");
    pin[0] = 1'b1; cyc(N + 6);
    // R6/R8 on ch1 falling
    wr(1, ctl(0, 0, 3'd2));
    pin[1] = 1'b1; cyc(N + 6); ack_pulse(1);
    pin[1] = 1'b0; cyc(N + 6);
    chk({7'd0, req[1]}, 8'd1, "R8 pending");
    wr(1, ctl(0, 0, 3'd6)); cyc(1);
    chk({7'd0, req[1]}, 8'd1, "R8 same mode keeps");
    chk({7'd0, prio[5:3]}, 8'd6, "R1 prio_o");
    wr(1, ctl(0, 0, 3'd0)); cyc(1);
    chk({7'd0, req[1]}, 8'd0, "R6 masked");
    wr(1, ctl(0, 0, 3'd7)); cyc(1);
    chk({7'd0, req[1]}, 8'd1, "R6 flag kept");
    wr(1, ctl(0, 1, 3'd7)); cyc(1);
    chk({7'd0, req[1]}, 8'd0, "R8 pol change clears");
    wr(1, ctl(0, 0, 3'd7)); cyc(1);
    chk({7'd0, req[1]}, 8'd0, "R8 no spurious");
    // R6 level mode with prio 0 never requests
    wr(2, ctl(1, 0, 3'd0));
    pin[2] = 1'b0; cyc(N + 6);
    chk({7'd0, req[2]}, 8'd0, "R6 level masked");
    wr(2, ctl(1, 0, 3'd1)); cyc(1);
    chk({7'd0, req[2]}, 8'd1, "R6 level unmasked");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule